// File: doc/BRIEF.md
# Byte-Register Multiply/Divide Coprocessor

This block is an arithmetic helper that a host processor reaches through sixteen byte-wide registers. The host writes operand bytes one at a time. Writing the top byte of the multiplier launches a 16x16 multiply. Writing the top byte of the divisor launches a 32/16 divide.

A mode bit selects two's-complement or unsigned arithmetic for both operations. The 32-bit result and 16-bit remainder are read back bytewise. A finished flag tells the host that an operation has completed, and reading that flag clears it.

The multiply runs as a shift-add sequence over 16 cycles. The divide runs as a restoring sequence over 32 cycles. A new trigger or a mode write cancels the operation in flight. The block carries no data stream, so there is no valid/ready pair. Every register access completes in the cycle it is presented, and no back-pressure exists. Read data is combinational while `rd_en` is high.

Top module: `bmu_top`

## Requirements
- R1: Register offsets on `addr` are fixed as follows:
  - 0..3: the dividend, least significant byte at offset 0. Offsets 0..1 also form the multiplicand.
  - 4..5: the multiplier, low byte first.
  - 6..7: the divisor, low byte first.
  - 8..B: the result, least significant byte at offset 8.
  - C..D: the remainder, low byte first.
  - E: the mode register.
  - F: the finished flag.

  After reset every register reads 0. Offsets 0..7 and E read back what was last written to them.
- R2: A write to offset 5 stores the byte and starts a multiply of {5,4} by {1,0}. The 32-bit product goes to the result registers, and the remainder registers are left unchanged.
- R3: A write to offset 7 stores the byte and starts a divide of {3,2,1,0} by {7,6}. The quotient goes to the result registers and the remainder to offsets C..D.
- R4: When mode bit 0 is 1, operands are two's complement. The product is the signed product. The quotient is truncated toward zero, with its sign the XOR of the operand signs. The remainder carries the dividend's sign. When mode bit 0 is 0, all arithmetic is unsigned.
- R5: A write to offset E clears offsets 0..D to zero and stores the written byte as the mode. It also cancels any running operation, so no result from that operation ever appears.
- R6: A read of offset F returns 0x80 while the flag is set and clears the flag; otherwise it returns 0x00. Reads of other offsets leave the flag alone.
- R7: The flag becomes set on the 17th rising edge after the edge that accepts a multiply trigger, and on the 33rd for a divide. If a flag read coincides with that edge, the flag ends up set.
- R8: A divide by zero sets the result to 0xFFFFFFFF and the remainder to the low 16 bits of the dividend as written. The flag becomes set on the first edge after the trigger.
- R9: A trigger that arrives while an operation runs cancels it and restarts with the current operands. Latency counts from the new trigger, and the cancelled operation never writes a result or sets the flag.
- R10: Writes to offsets 8..F have no effect on any register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| wr_en | input | 1 | Register write strobe, one access per cycle |
| rd_en | input | 1 | Register read strobe; a read of offset F clears the flag at the edge |
| addr | input | 4 | Register offset within the window |
| wdata | input | 8 | Write data byte |
| rdata | output | 8 | Read data byte, combinational, zero when rd_en is low |

## Verification
The hardest case to reach from the ports is a flag read that lands on the very edge where an operation completes. It needs a stimulus that counts edges exactly from the trigger write. The bench reads the flag one cycle before completion, expecting zero on the same edge that sets it, and then reads again expecting 0x80; this pins the latency to the cycle.

Cancellation is just as hard to see, because a cancelled run leaves no trace. The bench starts a divide and retriggers a multiply part-way through. It then checks that the remainder stays zero and that no late flag appears long after the divide would have ended. A mode write issued in mid-run is checked in the same way.

// File: rtl/bmu_pkg.sv
package bmu_pkg;
  localparam int OP_W  = 16;
  localparam int RES_W = 2 * OP_W;
  localparam int OPR_N = 8;

  localparam logic [3:0] OFS_MUL_HI = 4'h5;
  localparam logic [3:0] OFS_DIV_HI = 4'h7;
  localparam logic [3:0] OFS_MODE   = 4'hE;
  localparam logic [3:0] OFS_FLAG   = 4'hF;
  localparam logic [7:0] FLAG_SET   = 8'h80;
endpackage

// File: rtl/bmu_mul.sv
module bmu_mul #(
  parameter int W = 16
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           start,
  input  logic           kill,
  input  logic           sgn,
  input  logic [W-1:0]   op_a,
  input  logic [W-1:0]   op_b,
  output logic           busy,
  output logic           done,
  output logic [2*W-1:0] prod
);
  localparam int CW = $clog2(W);

  logic [2*W-1:0] acc, mcand, step_sum;
  logic [W-1:0]   mplier, a_mag, b_mag;
  logic [CW-1:0]  cnt;
  logic           neg;

  always_comb begin
    a_mag    = (sgn && op_a[W-1]) ? -op_a : op_a;
    b_mag    = (sgn && op_b[W-1]) ? -op_b : op_b;
    step_sum = acc + (mplier[0] ? mcand : '0);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc <= '0; mcand <= '0; mplier <= '0; cnt <= '0;
      neg <= 1'b0; busy <= 1'b0; done <= 1'b0; prod <= '0;
    end else begin
      done <= 1'b0;
      if (start) begin
        acc    <= '0;
        mcand  <= {{W{1'b0}}, a_mag};
        mplier <= b_mag;
        cnt    <= CW'(W - 1);
        neg    <= sgn && (op_a[W-1] ^ op_b[W-1]);
        busy   <= 1'b1;
      end else if (kill) begin
        busy <= 1'b0;
      end else if (busy) begin
        acc    <= step_sum;
        mcand  <= mcand << 1;
        mplier <= mplier >> 1;
        cnt    <= cnt - 1'b1;
        if (cnt == '0) begin
          busy <= 1'b0;
          done <= 1'b1;
          prod <= neg ? -step_sum : step_sum;
        end
      end
    end
  end
endmodule

// File: rtl/bmu_div.sv
module bmu_div #(
  parameter int W = 16
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           start,
  input  logic           kill,
  input  logic           sgn,
  input  logic [2*W-1:0] dividend,
  input  logic [W-1:0]   divisor,
  output logic           busy,
  output logic           done,
  output logic [2*W-1:0] quo,
  output logic [W-1:0]   rmd
);
  localparam int NW = 2 * W;
  localparam int CW = $clog2(NW);

  logic [NW-1:0] q, n_mag, nq;
  logic [W-1:0]  r, d, d_mag, nr;
  logic [W:0]    sh, trial;
  logic [CW-1:0] cnt;
  logic          qneg, rneg, ge;

  always_comb begin
    n_mag = (sgn && dividend[NW-1]) ? -dividend : dividend;
    d_mag = (sgn && divisor[W-1])   ? -divisor  : divisor;
    sh    = {r, q[NW-1]};
    trial = sh - {1'b0, d};
    ge    = !trial[W];
    nr    = ge ? trial[W-1:0] : sh[W-1:0];
    nq    = {q[NW-2:0], ge};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      q <= '0; r <= '0; d <= '0; cnt <= '0; qneg <= 1'b0; rneg <= 1'b0;
      busy <= 1'b0; done <= 1'b0; quo <= '0; rmd <= '0;
    end else begin
      done <= 1'b0;
      if (start) begin
        if (divisor == '0) begin
          busy <= 1'b0;
          done <= 1'b1;
          quo  <= '1;
          rmd  <= dividend[W-1:0];
        end else begin
          q    <= n_mag;
          r    <= '0;
          d    <= d_mag;
          cnt  <= CW'(NW - 1);
          qneg <= sgn && (dividend[NW-1] ^ divisor[W-1]);
          rneg <= sgn && dividend[NW-1];
          busy <= 1'b1;
        end
      end else if (kill) begin
        busy <= 1'b0;
      end else if (busy) begin
        q   <= nq;
        r   <= nr;
        cnt <= cnt - 1'b1;
        if (cnt == '0) begin
          busy <= 1'b0;
          done <= 1'b1;
          quo  <= qneg ? -nq : nq;
          rmd  <= rneg ? -nr : nr;
        end
      end
    end
  end
endmodule

// File: rtl/bmu_top.sv
module bmu_top
  import bmu_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wr_en,
  input  logic       rd_en,
  input  logic [3:0] addr,
  input  logic [7:0] wdata,
  output logic [7:0] rdata
);
  logic [7:0]       opr [OPR_N];
  logic [RES_W-1:0] res_q;
  logic [OP_W-1:0]  rem_q;
  logic [7:0]       mode_q;
  logic             fin_q;

  logic wr_mode, mul_go, div_go, rd_flag, done_any;
  logic mul_busy, mul_done, div_busy, div_done;
  logic [RES_W-1:0] mul_res, div_q;
  logic [OP_W-1:0]  div_r;

  assign wr_mode  = wr_en && (addr == OFS_MODE);
  assign mul_go   = wr_en && (addr == OFS_MUL_HI);
  assign div_go   = wr_en && (addr == OFS_DIV_HI);
  assign rd_flag  = rd_en && (addr == OFS_FLAG);
  assign done_any = mul_done || div_done;

  bmu_mul #(.W(OP_W)) u_mul (
    .clk(clk), .rst_n(rst_n), .start(mul_go), .kill(wr_mode | div_go),
    .sgn(mode_q[0]), .op_a({opr[1], opr[0]}), .op_b({wdata, opr[4]}),
    .busy(mul_busy), .done(mul_done), .prod(mul_res)
  );

  bmu_div #(.W(OP_W)) u_div (
    .clk(clk), .rst_n(rst_n), .start(div_go), .kill(wr_mode | mul_go),
    .sgn(mode_q[0]), .dividend({opr[3], opr[2], opr[1], opr[0]}),
    .divisor({wdata, opr[6]}),
    .busy(div_busy), .done(div_done), .quo(div_q), .rmd(div_r)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < OPR_N; i++) opr[i] <= '0;
      res_q <= '0; rem_q <= '0; mode_q <= '0; fin_q <= 1'b0;
    end else begin
      if (wr_mode) begin
        for (int i = 0; i < OPR_N; i++) opr[i] <= '0;
        res_q  <= '0;
        rem_q  <= '0;
        mode_q <= wdata;
      end else begin
        if (wr_en && !addr[3]) opr[addr[2:0]] <= wdata;
        if (mul_done) res_q <= mul_res;
        if (div_done) begin
          res_q <= div_q;
          rem_q <= div_r;
        end
      end
      if (done_any && !wr_mode) fin_q <= 1'b1;
      else if (rd_flag)         fin_q <= 1'b0;
    end
  end

  always_comb begin
    rdata = '0;
    if (rd_en) begin
      case (addr)
        4'h8, 4'h9, 4'hA, 4'hB: rdata = res_q[8*addr[1:0] +: 8];
        4'hC, 4'hD:             rdata = rem_q[8*addr[0] +: 8];
        OFS_MODE:               rdata = mode_q;
        OFS_FLAG:               rdata = fin_q ? FLAG_SET : 8'h00;
        default:                rdata = opr[addr[2:0]];
      endcase
    end
  end
endmodule

// File: rtl/bmu_checker.sv
module bmu_checker (
  input logic        clk,
  input logic        rst_n,
  input logic        wr_en,
  input logic        rd_en,
  input logic [3:0]  addr,
  input logic [7:0]  rdata,
  input logic        fin,
  input logic [31:0] res,
  input logic [15:0] rem,
  input logic        mul_busy,
  input logic        div_busy,
  input logic        done_any
);
  p_flag_read_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && addr == 4'hF) |-> (rdata == (fin ? 8'h80 : 8'h00)));

  p_flag_clear_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && addr == 4'hF && !done_any) |=> !fin);

  p_mode_wipe_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == 4'hE) |=> (res == '0 && rem == '0 && !mul_busy && !div_busy));

  p_ro_result_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr >= 4'h8 && addr <= 4'hD && !done_any) |=> ($stable(res) && $stable(rem)));

  p_one_engine_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({mul_busy, div_busy}));
endmodule

bind bmu_top bmu_checker u_chk (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
  .rdata(rdata), .fin(fin_q), .res(res_q), .rem(rem_q),
  .mul_busy(mul_busy), .div_busy(div_busy), .done_any(done_any)
);

// File: tb/bmu_top_bench.sv
module bmu_top_bench;
  logic clk = 1'b0, rst_n = 1'b0, wr_en = 1'b0, rd_en = 1'b0;
  logic [3:0] addr = '0;
  logic [7:0] wdata = '0, rdata;
  int checks = 0, errors = 0;
  bit finished = 1'b0;

  always #2 clk = ~clk;

  bmu_top u_bmu_top (.clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en),
                     .addr(addr), .wdata(wdata), .rdata(rdata));

  // {div_op, signed_mode, a[31:0], b[15:0]}
  localparam logic [49:0] VEC [12] = '{
    {1'b0, 1'b0, 32'h0000_1234, 16'h5678},
    {1'b0, 1'b0, 32'h0000_FFFF, 16'hFFFF},
    {1'b0, 1'b1, 32'h0000_FFFE, 16'h0003},
    {1'b0, 1'b1, 32'h0000_8000, 16'h8000},
    {1'b0, 1'b1, 32'h0000_7FFF, 16'h8000},
    {1'b1, 1'b0, 32'h1234_5678, 16'h1234},
    {1'b1, 1'b0, 32'hFFFF_FFFF, 16'h0001},
    {1'b1, 1'b0, 32'h0000_0005, 16'h0007},
    {1'b1, 1'b1, 32'hFFFF_FF9C, 16'h0007},
    {1'b1, 1'b1, 32'h0000_0064, 16'hFFF9},
    {1'b1, 1'b1, 32'h8000_0000, 16'hFFFF},
    {1'b1, 1'b1, 32'hFFFF_FFF9, 16'hFFFE}
  };

  function automatic logic [47:0] model(logic dv, logic sg, logic [31:0] a, logic [15:0] b);
    longint n, d, q, r, p;
    logic [31:0] res;
    logic [15:0] rem;
    rem = '0;
    if (!dv) begin
      if (sg) begin
        p = longint'($signed(a[15:0])) * longint'($signed(b));
        res = p[31:0];
      end else res = {16'h0, a[15:0]} * {16'h0, b};
    end else if (b == 16'h0) begin
      res = 32'hFFFF_FFFF; rem = a[15:0];
    end else begin
      if (sg) begin
        n = longint'($signed(a)); d = longint'($signed(b));
      end else begin
        n = longint'({32'h0, a}); d = longint'({48'h0, b});
      end
      q = n / d; r = n % d;
      res = q[31:0]; rem = r[15:0];
    end
    return {res, rem};
  endfunction

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(logic [3:0] a, logic [7:0] d);
    @(negedge clk); wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic rd(logic [3:0] a, output logic [7:0] v);
    @(negedge clk); rd_en = 1'b1; addr = a;
    #1 v = rdata;
    @(negedge clk); rd_en = 1'b0;
  endtask

  task automatic rd_res(output logic [31:0] r, output logic [15:0] m);
    logic [7:0] v;
    for (int k = 0; k < 4; k++) begin rd(4'(8 + k), v); r[8*k +: 8] = v; end
    for (int k = 0; k < 2; k++) begin rd(4'(12 + k), v); m[8*k +: 8] = v; end
  endtask

  task automatic edge_check(string tag, int lat);
    logic [7:0] v;
    repeat (lat - 2) @(negedge clk);
    rd(4'hF, v); chk({tag, " flag before completion"}, 32'(v), 32'h00);
    rd(4'hF, v); chk({tag, " flag at completion"}, 32'(v), 32'h80);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [7:0] v;
    logic [31:0] r;
    logic [15:0] m;
    logic [47:0] e;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1: reset state
    for (int k = 0; k < 16; k++) begin
      rd(4'(k), v); chk($sformatf("R1 reset offset %0d", k), 32'(v), 32'h0);
    end
    // R1: operand readback
    wr(4'h0, 8'hA5); wr(4'h3, 8'h3C); wr(4'h6, 8'h81);
    rd(4'h0, v); chk("R1 readback 0", 32'(v), 32'hA5);
    rd(4'h3, v); chk("R1 readback 3", 32'(v), 32'h3C);
    rd(4'h6, v); chk("R1 readback 6", 32'(v), 32'h81);

    // vector walk: R2 R3 R4 R7
    for (int i = 0; i < 12; i++) begin
      logic dv, sg; logic [31:0] a; logic [15:0] b;
      {dv, sg, a, b} = VEC[i];
      e = model(dv, sg, a, b);
      wr(4'hE, {7'h0, sg});
      for (int k = 0; k < 4; k++) wr(4'(k), a[8*k +: 8]);
      if (!dv) begin wr(4'h4, b[7:0]); wr(4'h5, b[15:8]); end
      else     begin wr(4'h6, b[7:0]); wr(4'h7, b[15:8]); end
      edge_check($sformatf("R7 vec %0d", i), dv ? 33 : 17);
      rd_res(r, m);
      chk($sformatf("%s vec %0d result", dv ? "R3/R4" : "R2/R4", i), r, e[47:16]);
      chk($sformatf("%s vec %0d remainder", dv ? "R3/R4" : "R2", i), 32'(m), 32'(e[15:0]));
    end

    // R6: other reads do not clear the flag
    wr(4'hE, 8'h00); wr(4'h0, 8'h07); wr(4'h4, 8'h06); wr(4'h5, 8'h00);
    repeat (20) @(negedge clk);
    rd_res(r, m);
    chk("R2 small product", r, 32'd42);
    rd(4'hF, v); chk("R6 flag kept by other reads", 32'(v), 32'h80);
    rd(4'hF, v); chk("R6 flag cleared by read", 32'(v), 32'h00);

    // R10: writes to result, remainder, flag ignored
    for (int k = 8; k < 14; k++) wr(4'(k), 8'h55);
    wr(4'hF, 8'hFF);
    rd_res(r, m);
    chk("R10 result unchanged", r, 32'd42);
    chk("R10 remainder unchanged", 32'(m), 32'h0);
    rd(4'hF, v); chk("R10 flag unchanged", 32'(v), 32'h00);

    // R8: divide by zero, signed mode
    wr(4'hE, 8'h01);
    wr(4'h0, 8'hEF); wr(4'h1, 8'hCD); wr(4'h2, 8'hAB); wr(4'h3, 8'h89);
    wr(4'h6, 8'h00); wr(4'h7, 8'h00);
    rd(4'hF, v); chk("R8 flag one edge after trigger", 32'(v), 32'h80);
    rd_res(r, m);
    chk("R8 result all ones", r, 32'hFFFF_FFFF);
    chk("R8 remainder low dividend", 32'(m), 32'hCDEF);

    // R9: retrigger cancels running divide
    wr(4'hE, 8'h00);
    wr(4'h0, 8'h64); wr(4'h6, 8'h03); wr(4'h7, 8'h00);
    repeat (5) @(negedge clk);
    wr(4'h4, 8'h05); wr(4'h5, 8'h00);
    edge_check("R9 retrigger", 17);
    rd_res(r, m);
    chk("R9 product of new op", r, 32'd500);
    chk("R9 no divide remainder", 32'(m), 32'h0);
    repeat (40) @(negedge clk);
    rd(4'hF, v); chk("R9 no late flag", 32'(v), 32'h00);

    // R5: mode write cancels and wipes
    wr(4'h0, 8'h11); wr(4'h4, 8'h22); wr(4'h5, 8'h00);
    repeat (3) @(negedge clk);
    wr(4'hE, 8'h01);
    repeat (40) @(negedge clk);
    rd(4'hF, v); chk("R5 no flag after cancel", 32'(v), 32'h00);
    rd_res(r, m);
    chk("R5 result wiped", r, 32'h0);
    rd(4'h0, v); chk("R5 operand wiped", 32'(v), 32'h0);
    rd(4'h4, v); chk("R5 multiplier wiped", 32'(v), 32'h0);
    rd(4'hE, v); chk("R5 mode stored", 32'(v), 32'h01);

    finished = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule